// File: doc/BRIEF.md
# Read Latency Start Calculator

This block computes the first value a read-latency training sweep tries on one DRAM channel, and the safety margin added once the sweep has found a passing delay. The first value is a count of northbridge clocks. It takes the channel's timing settings:

- CAS latency
- DIMM buffering
- address, chip-select and CKE setup flags
- read pointer init
- worst-case receiver enable delay

From these it builds a latency budget in half memory clocks. It then converts that budget into northbridge clocks using the ratio of the memory clock code to the northbridge frequency ID.

A pulse on `start_i` samples every input. Two restoring dividers then run side by side, one bit per cycle. One divider produces the start latency and the other produces the margin. When they finish, `done_o` pulses for one cycle. The results stay on `lat_o` and `margin_o` until the next computation completes. A start that arrives while a computation is in progress is dropped.

Top module: `rdlat_start_calc`

## Requirements
- R1: After reset, `lat_o` and `margin_o` are 0 and `done_o` is low.
- R2: The budget in half memory clocks is the sum of these terms, then minus `rdptr_i`:
  - 2 × (`cas_i` + 1)
  - 2 when `unbuf_i` is 0, otherwise 0
  - 1 when all three setup flags are 0, otherwise 2
  - 8
  - `rcven_dly_i[7:5]`, truncated
  The quarter-clock budget is twice this value.
- R3: When `rdptr_i` exceeds the rest of the budget, the budget is 0 instead of going negative.
- R4: For memory clock code m = `memclk_code_i`, the memory factor is 2m when m ≥ 3 and m + 3 otherwise. The divisor is 4 × the memory factor.
- R5: The northbridge factor is 3 × (`nb_fid_i` + 4).
- R6: `lat_o` = ceil(northbridge factor × quarter-clock budget / divisor), limited to 1023.
- R7: `margin_o` = ceil(4 × northbridge factor / divisor) + 1.
- R8: `done_o` is high for exactly one cycle. It is first high after the 18th rising edge that follows the edge on which `start_i` was accepted. The new `lat_o` and `margin_o` appear in that same cycle.
- R9: A `start_i` that arrives between the accepting edge and the 17th edge after it is ignored. The running computation's inputs and timing are kept.
- R10: `lat_o` and `margin_o` change only in a cycle where `done_o` is high. Input changes without an accepted start leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Sample inputs and begin a computation |
| cas_i | input | 4 | CAS latency field |
| unbuf_i | input | 1 | 1 = unbuffered DIMMs, 0 = registered |
| setup_addr_i | input | 1 | Address/command setup flag |
| setup_cs_i | input | 1 | Chip-select/ODT setup flag |
| setup_cke_i | input | 1 | CKE setup flag |
| rdptr_i | input | 4 | Read pointer init field |
| rcven_dly_i | input | 8 | Worst-case receiver enable delay |
| memclk_code_i | input | 3 | Memory clock frequency code |
| nb_fid_i | input | 5 | Northbridge frequency ID |
| done_o | output | 1 | One-cycle result strobe |
| lat_o | output | 10 | Start latency in northbridge clocks |
| margin_o | output | 6 | Margin in northbridge clocks |

## Verification
The hardest state to reach is a start that arrives in the middle of a divider run. Input values that differ from the running job must be present at that moment, so that a wrongly accepted start would show up as different results or a shifted strobe. The bench launches one vector, waits a few cycles, then pulses start with a second vector on the pins. It then checks that the first vector's results arrive on the original schedule. The clamped budget is another corner that is easy to miss. It is reached with a vector whose `rdptr_i` exceeds the other budget terms, and with a second vector that cancels them exactly.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;
  localparam int unsigned LANES    = 2;
  localparam int unsigned LANE_LAT = 0;
  localparam int unsigned LANE_MG  = 1;
  localparam int unsigned RDPTR_BIAS = 8;
endpackage

// File: rtl/rdlat_budget.sv
module rdlat_budget
  import rdlat_pkg::*;
#(
  parameter int unsigned CAS_W   = 4,
  parameter int unsigned RDPTR_W = 4,
  parameter int unsigned RCV_W   = 8,
  parameter int unsigned MCLK_W  = 3,
  parameter int unsigned FID_W   = 5,
  parameter int unsigned SUB_W   = CAS_W + 4,
  parameter int unsigned NB_W    = FID_W + 3,
  parameter int unsigned DVS_W   = MCLK_W + 4,
  parameter int unsigned PROD_W  = NB_W + SUB_W + 1
) (
  input  logic [CAS_W-1:0]   cas_i,
  input  logic               unbuf_i,
  input  logic [2:0]         setup_i,
  input  logic [RDPTR_W-1:0] rdptr_i,
  input  logic [RCV_W-1:0]   rcven_dly_i,
  input  logic [MCLK_W-1:0]  memclk_code_i,
  input  logic [FID_W-1:0]   nb_fid_i,
  output logic [PROD_W-1:0]  dvd_lat_o,
  output logic [PROD_W-1:0]  dvd_mg_o,
  output logic [DVS_W-1:0]   dvs_o
);
  localparam int unsigned COARSE_SH = RCV_W - 3;
  localparam int unsigned QTR_W     = SUB_W + 1;

  logic [SUB_W-1:0]  pos, sub;
  logic [QTR_W-1:0]  qtr;
  logic [MCLK_W:0]   mfac;
  logic [NB_W-1:0]   nbf;

  always_comb begin
    pos = (SUB_W'(cas_i) + SUB_W'(1)) << 1;
    pos = pos + (unbuf_i ? SUB_W'(0) : SUB_W'(2));
    pos = pos + ((|setup_i) ? SUB_W'(2) : SUB_W'(1));
    pos = pos + SUB_W'(RDPTR_BIAS);
    pos = pos + SUB_W'(rcven_dly_i >> COARSE_SH);
    // clamp instead of wrapping below zero
    sub = (pos >= SUB_W'(rdptr_i)) ? pos - SUB_W'(rdptr_i) : '0;
    qtr = {sub, 1'b0};
  end

  always_comb begin
    if (memclk_code_i >= MCLK_W'(3)) mfac = {memclk_code_i, 1'b0};
    else                            mfac = {1'b0, memclk_code_i} + (MCLK_W+1)'(3);
    dvs_o = DVS_W'(mfac) << 2;
    nbf   = (NB_W'(nb_fid_i) + NB_W'(4)) * NB_W'(3);
  end

  assign dvd_lat_o = PROD_W'(nbf) * PROD_W'(qtr);
  assign dvd_mg_o  = PROD_W'(nbf) << 2;
endmodule

// File: rtl/rdlat_div.sv
module rdlat_div #(
  parameter int unsigned N_W = 17,
  parameter int unsigned D_W = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N_W-1:0] dividend_i,
  input  logic [D_W-1:0] divisor_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [N_W-1:0] quo_o,
  output logic [D_W-1:0] rem_o
);
  localparam int unsigned CNT_W = $clog2(N_W + 1);

  logic [N_W-1:0]   quo_q;
  logic [D_W-1:0]   rem_q, dvs_q, rem_nxt;
  logic [D_W:0]     shifted;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q, ge;

  always_comb begin
    shifted = {rem_q, quo_q[N_W-1]};
    ge      = shifted >= {1'b0, dvs_q};
    rem_nxt = ge ? D_W'(shifted - {1'b0, dvs_q}) : shifted[D_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      quo_q  <= dividend_i;
      rem_q  <= '0;
      dvs_q  <= divisor_i;
      cnt_q  <= CNT_W'(N_W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      quo_q <= {quo_q[N_W-2:0], ge};
      rem_q <= rem_nxt;
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/rdlat_start_calc.sv
module rdlat_start_calc
  import rdlat_pkg::*;
#(
  parameter int unsigned CAS_W    = 4,
  parameter int unsigned RDPTR_W  = 4,
  parameter int unsigned RCV_W    = 8,
  parameter int unsigned MCLK_W   = 3,
  parameter int unsigned FID_W    = 5,
  parameter int unsigned LAT_W    = 10,
  parameter int unsigned MARGIN_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [CAS_W-1:0]    cas_i,
  input  logic                unbuf_i,
  input  logic                setup_addr_i,
  input  logic                setup_cs_i,
  input  logic                setup_cke_i,
  input  logic [RDPTR_W-1:0]  rdptr_i,
  input  logic [RCV_W-1:0]    rcven_dly_i,
  input  logic [MCLK_W-1:0]   memclk_code_i,
  input  logic [FID_W-1:0]    nb_fid_i,
  output logic                done_o,
  output logic [LAT_W-1:0]    lat_o,
  output logic [MARGIN_W-1:0] margin_o
);
  localparam int unsigned SUB_W  = CAS_W + 4;
  localparam int unsigned NB_W   = FID_W + 3;
  localparam int unsigned DVS_W  = MCLK_W + 4;
  localparam int unsigned PROD_W = NB_W + SUB_W + 1;
  localparam logic [PROD_W:0] LAT_MAX = (PROD_W+1)'((1 << LAT_W) - 1);

  logic [PROD_W-1:0] dvd [LANES];
  logic [PROD_W-1:0] quo [LANES];
  logic [DVS_W-1:0]  rem [LANES];
  logic [DVS_W-1:0]  dvs;
  logic [LANES-1:0]  lane_busy, lane_done;
  logic              busy, go;
  logic [PROD_W:0]   lat_ceil;
  logic [PROD_W:0]   mg_ceil;

  assign busy = |lane_busy;
  assign go   = start_i & ~busy;

  rdlat_budget #(
    .CAS_W(CAS_W), .RDPTR_W(RDPTR_W), .RCV_W(RCV_W), .MCLK_W(MCLK_W),
    .FID_W(FID_W), .SUB_W(SUB_W), .NB_W(NB_W), .DVS_W(DVS_W), .PROD_W(PROD_W)
  ) u_budget (
    .cas_i        (cas_i),
    .unbuf_i      (unbuf_i),
    .setup_i      ({setup_addr_i, setup_cs_i, setup_cke_i}),
    .rdptr_i      (rdptr_i),
    .rcven_dly_i  (rcven_dly_i),
    .memclk_code_i(memclk_code_i),
    .nb_fid_i     (nb_fid_i),
    .dvd_lat_o    (dvd[LANE_LAT]),
    .dvd_mg_o     (dvd[LANE_MG]),
    .dvs_o        (dvs)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rdlat_div #(.N_W(PROD_W), .D_W(DVS_W)) u_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (go),
      .dividend_i(dvd[g]),
      .divisor_i (dvs),
      .busy_o    (lane_busy[g]),
      .done_o    (lane_done[g]),
      .quo_o     (quo[g]),
      .rem_o     (rem[g])
    );
  end

  // ceiling from quotient and remainder
  assign lat_ceil = {1'b0, quo[LANE_LAT]} + (PROD_W+1)'(rem[LANE_LAT] != '0);
  assign mg_ceil  = {1'b0, quo[LANE_MG]} + (PROD_W+1)'(rem[LANE_MG] != '0)
                  + (PROD_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      lat_o    <= '0;
      margin_o <= '0;
    end else begin
      done_o <= lane_done[LANE_LAT];
      if (lane_done[LANE_LAT]) begin
        lat_o    <= (lat_ceil > LAT_MAX) ? LAT_MAX[LAT_W-1:0] : lat_ceil[LAT_W-1:0];
        margin_o <= mg_ceil[MARGIN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/rdlat_start_calc_chk.sv
module rdlat_start_calc_chk #(
  parameter int unsigned LAT_W    = 10,
  parameter int unsigned MARGIN_W = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                busy_i,
  input logic                done_o,
  input logic [LAT_W-1:0]    lat_o,
  input logic [MARGIN_W-1:0] margin_o
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |=> done_o); // R8
  AST_START_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |=> busy_i); // R9
  AST_LAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lat_o) |-> done_o); // R10
  AST_MARGIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(margin_o) |-> done_o); // R10
  AST_MARGIN_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (margin_o >= MARGIN_W'(2))); // R7
endmodule

bind rdlat_start_calc rdlat_start_calc_chk #(.LAT_W(LAT_W), .MARGIN_W(MARGIN_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_i  (busy),
  .done_o  (done_o),
  .lat_o   (lat_o),
  .margin_o(margin_o)
);

// File: tb/sim_rdlat_start_calc.sv
`timescale 1ns/1ps
module sim_rdlat_start_calc;
  typedef struct packed {
    logic [3:0] cas;
    logic       unbuf;
    logic       sa;
    logic       sc;
    logic       sk;
    logic [3:0] rdptr;
    logic [7:0] rcv;
    logic [2:0] mclk;
    logic [4:0] fid;
    logic [9:0] exp_lat;
    logic [5:0] exp_mg;
  } vec_t;

  localparam int NV = 8;
  localparam int DONE_EDGES = 18;
  // expected values hand-computed from R2..R7
  localparam vec_t VECS [NV] = '{
    '{4'd5,  1'b1, 1'b0, 1'b0, 1'b0, 4'd6,  8'h45, 3'd2, 5'd6,  10'd51,  6'd7},
    '{4'd7,  1'b0, 1'b1, 1'b0, 1'b0, 4'd5,  8'hE0, 3'd4, 5'd10, 10'd79,  6'd7},
    '{4'd3,  1'b1, 1'b0, 1'b0, 1'b1, 4'd7,  8'h1F, 3'd0, 5'd0,  10'd22,  6'd5},
    '{4'd15, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  8'hFF, 3'd0, 5'd31, 10'd893, 6'd36},
    '{4'd9,  1'b1, 1'b1, 1'b1, 1'b1, 4'd4,  8'h60, 3'd7, 5'd2,  10'd19,  6'd3},
    '{4'd0,  1'b1, 1'b0, 1'b0, 1'b0, 4'd15, 8'h00, 3'd3, 5'd1,  10'd0,   6'd4},
    '{4'd0,  1'b1, 1'b0, 1'b0, 1'b0, 4'd11, 8'h00, 3'd1, 5'd4,  10'd0,   6'd7},
    '{4'd0,  1'b1, 1'b0, 1'b0, 1'b0, 4'd10, 8'h00, 3'd5, 5'd12, 10'd3,   6'd6}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] cas = '0;
  logic       unbuf = 1'b0, sa = 1'b0, sc = 1'b0, sk = 1'b0;
  logic [3:0] rdptr = '0;
  logic [7:0] rcv = '0;
  logic [2:0] mclk = '0;
  logic [4:0] fid = '0;
  logic       done;
  logic [9:0] lat;
  logic [5:0] mg;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  rdlat_start_calc u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cas_i(cas), .unbuf_i(unbuf),
    .setup_addr_i(sa), .setup_cs_i(sc), .setup_cke_i(sk), .rdptr_i(rdptr),
    .rcven_dly_i(rcv), .memclk_code_i(mclk), .nb_fid_i(fid),
    .done_o(done), .lat_o(lat), .margin_o(mg)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    cas = v.cas; unbuf = v.unbuf; sa = v.sa; sc = v.sc; sk = v.sk;
    rdptr = v.rdptr; rcv = v.rcv; mclk = v.mclk; fid = v.fid;
  endtask

  // start on one edge, count edges until done visible
  task automatic run(input vec_t v, input int intr, input vec_t w, output int edges);
    @(negedge clk);
    apply(v);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    edges = 0;
    while (!done && edges < 100) begin
      if (intr != 0 && edges == intr) begin
        apply(w);
        start = 1'b1;
      end
      @(posedge clk);
      edges++;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  initial begin
    int edges;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 lat reset", int'(lat), 0);
    check("R1 margin reset", int'(mg), 0);
    check("R1 done reset", int'(done), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run(VECS[i], 0, VECS[i], edges);
      check($sformatf("R2 R4 R5 R6 lat vec%0d", i), int'(lat), int'(VECS[i].exp_lat));
      check($sformatf("R7 margin vec%0d", i), int'(mg), int'(VECS[i].exp_mg));
      check($sformatf("R8 done delay vec%0d", i), edges, DONE_EDGES);
      @(negedge clk);
      check($sformatf("R8 done width vec%0d", i), int'(done), 0);
    end

    // R3 clamp: budget would be -4, and exact zero
    run(VECS[5], 0, VECS[5], edges);
    check("R3 clamp below zero", int'(lat), 0);
    run(VECS[6], 0, VECS[6], edges);
    check("R3 exact zero budget", int'(lat), 0);
    run(VECS[7], 0, VECS[7], edges);
    check("R3 one above zero", int'(lat), 3);

    // R10 inputs change without start
    run(VECS[3], 0, VECS[3], edges);
    apply(VECS[4]);
    repeat (6) @(negedge clk);
    check("R10 lat held", int'(lat), 893);
    check("R10 margin held", int'(mg), 36);
    check("R10 no strobe", int'(done), 0);

    // R9 start mid-run with other inputs is dropped
    run(VECS[1], 3, VECS[3], edges);
    check("R9 lat from first start", int'(lat), 79);
    check("R9 margin from first start", int'(mg), 7);
    check("R9 timing kept", edges, DONE_EDGES);
    repeat (25) @(negedge clk);
    check("R9 no second strobe", int'(done), 0);
    check("R9 lat after ignored start", int'(lat), 79);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule